// File: doc/BRIEF.md
# Multi-Mode Timer/Counter with Capture

This block is a 16-bit counter made of two 8-bit halves. A two-bit mode field decides how the halves are used. They can run as two separate prescaled timers. The low half can run as a prescaled timer while the high half counts external events. The two halves can also be joined into one 16-bit prescaled timer, or into one 16-bit event counter. The counter itself is not visible at the ports. Software reads it through two capture registers, which latch the counter when an edge arrives on a capture strobe.

Time inside the block advances only on cycles where the cycle-rate enable is high. The event input and both strobes pass through a two-flop synchronizer. They are then sampled on enabled cycles, and the bench selects either the rising or the falling edge. A pulse therefore has to span an enabled sample to be seen. Each half has a sticky overflow flag that software clears by writing a one. Configuration is written through a small port with three addresses: control (address 0), prescaler reload (address 1) and flag clear (address 2).

Top module: `mtc_timer`

## Requirements
- R1: After reset, both capture registers read 0 and both overflow flags are low.
- R2: The prescaler reloads with the value P written at address 1. It emits one tick every P+1 enabled cycles, and each tick advances a prescaled timer by one.
- R3: A write to address 0 loads the control word: bits 1:0 select the mode, bit 2 is run, bit 3 selects a falling event edge and bit 4 selects a falling strobe edge. The same write clears both counter halves and reloads the prescaler. While run is 0, nothing counts.
- R4: Mode 0 runs both halves as independent 8-bit prescaled timers. The low strobe captures only the low half, and the high strobe captures only the high half.
- R5: Mode 1 runs the low half as a prescaled timer, and the high half counts one per selected event edge.
- R6: Mode 2 joins the halves into one 16-bit prescaled timer. The low strobe latches all 16 bits on one edge, with the low byte in the low capture register and the high byte in the high one. The high strobe has no effect.
- R7: Mode 3 joins the halves into one 16-bit counter that advances once per selected event edge. The low strobe captures all 16 bits, as in mode 2.
- R8: With the selected edge set to falling, only high-to-low transitions count as events or trigger a capture. Low-to-high transitions are then ignored.
- R9: Inputs are sampled only on enabled cycles. A pulse that is high for no enabled sample is ignored. A pulse that spans one enabled sample counts exactly once. Capture registers and flags change only after an enabled cycle.
- R10: The low flag sets when the low half wraps from all ones in modes 0 and 1, and never in modes 2 and 3. The high flag sets when the high half wraps, which is the 16-bit wrap in modes 2 and 3. Flags stay set until a write to address 2 with bit 0 (low flag) or bit 1 (high flag) set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | Cycle-rate enable; timing advances only when high |
| evt_in | input | 1 | External event input |
| cap_lo_in | input | 1 | Capture strobe for the low half, or for all 16 bits in the joined modes |
| cap_hi_in | input | 1 | Capture strobe for the high half |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 prescaler reload, 2 flag clear |
| wr_data | input | 8 | Write data |
| cap_lo_q | output | 8 | Low capture register |
| cap_hi_q | output | 8 | High capture register |
| ovf_lo | output | 1 | Sticky overflow flag of the low half |
| ovf_hi | output | 1 | Sticky overflow flag of the high half |

## Verification
The assertions assume that reset is applied from the first clock. They also assume that the cycle enable is the only thing that lets sampled inputs through: a flag rise or a capture change must follow an enabled cycle. Finally, they assume that the only flag-clear path is a write to address 2. The stimulus changes all inputs away from the clock edge. Strobes and event pulses are held across at least one enabled sample, except for the deliberately short pulses that test R9. Counter values are measured as differences between two captures taken an exact number of cycles apart. Because both captures pass through the same synchronizer delay, that fixed latency cancels out of each expected value.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

    typedef enum logic [1:0] {
        MD_SPLIT    = 2'd0,
        MD_MIXED    = 2'd1,
        MD_WIDE_TMR = 2'd2,
        MD_WIDE_CNT = 2'd3
    } mode_e;

    typedef struct packed {
        logic  cap_fall;
        logic  evt_fall;
        logic  run;
        mode_e mode;
    } ctrl_t;

    localparam int unsigned ADDR_CTRL    = 0;
    localparam int unsigned ADDR_RELOAD  = 1;
    localparam int unsigned ADDR_FLAGCLR = 2;

    localparam int SRC_EVT   = 0;
    localparam int SRC_CAPLO = 1;
    localparam int SRC_CAPHI = 2;
    localparam int NUM_SRC   = 3;

    function automatic logic is_wide(input mode_e m);
        return (m == MD_WIDE_TMR) || (m == MD_WIDE_CNT);
    endfunction

    function automatic ctrl_t decode_ctrl(input logic [4:0] d);
        ctrl_t c;
        c.mode     = mode_e'(d[1:0]);
        c.run      = d[2];
        c.evt_fall = d[3];
        c.cap_fall = d[4];
        return c;
    endfunction

endpackage

// File: rtl/mtc_edge_sync.sv
module mtc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic din,
    input  logic fall_sel,
    output logic hit
);
    logic [STAGES-1:0] chain;
    logic              prev;
    logic              cur;

    assign cur = chain[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            if (en) prev <= cur;
        end
    end

    assign hit = en & (fall_sel ? (prev & ~cur) : (~prev & cur));
endmodule

// File: rtl/mtc_prescaler.sv
module mtc_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         load,
    input  logic [W-1:0] reload,
    output logic         tick
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)          cnt <= '0;
        else if (load)    cnt <= reload;
        else if (en)      cnt <= (cnt == '0) ? reload : cnt - W'(1);
    end

    assign tick = en & ~load & (cnt == '0);
endmodule

// File: rtl/mtc_count_core.sv
module mtc_count_core
    import mtc_pkg::*;
#(
    parameter int HW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  mode_e         mode,
    input  logic          tick,
    input  logic          evt,
    output logic [HW-1:0] lo,
    output logic [HW-1:0] hi,
    output logic          wrap_lo,
    output logic          wrap_hi
);
    logic inc_lo;
    logic inc_hi;

    always_comb begin
        inc_lo = (mode == MD_WIDE_CNT) ? evt : tick;
        unique case (mode)
            MD_SPLIT: inc_hi = tick;
            MD_MIXED: inc_hi = evt;
            default:  inc_hi = inc_lo & (&lo);
        endcase
    end

    assign wrap_lo = inc_lo & (&lo);
    assign wrap_hi = inc_hi & (&hi);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lo <= '0;
            hi <= '0;
        end else begin
            if (inc_lo) lo <= lo + HW'(1);
            if (inc_hi) hi <= hi + HW'(1);
        end
    end
endmodule

// File: rtl/mtc_timer.sv
module mtc_timer
    import mtc_pkg::*;
#(
    parameter int HALF_W      = 8,
    parameter int PRE_W       = 8,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_en,
    input  logic              evt_in,
    input  logic              cap_lo_in,
    input  logic              cap_hi_in,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [HALF_W-1:0] cap_lo_q,
    output logic [HALF_W-1:0] cap_hi_q,
    output logic              ovf_lo,
    output logic              ovf_hi
);
    ctrl_t             cfg_q;
    logic [PRE_W-1:0]  reload_q;
    logic              wr_ctrl, wr_reload, wr_flag;
    logic              flag_clr_lo, flag_clr_hi;
    logic              wide;

    assign wr_ctrl     = wr_en && (wr_addr == 2'(ADDR_CTRL));
    assign wr_reload   = wr_en && (wr_addr == 2'(ADDR_RELOAD));
    assign wr_flag     = wr_en && (wr_addr == 2'(ADDR_FLAGCLR));
    assign flag_clr_lo = wr_flag & wr_data[0];
    assign flag_clr_hi = wr_flag & wr_data[1];
    assign wide        = is_wide(cfg_q.mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            reload_q <= '0;
        end else begin
            if (wr_ctrl)   cfg_q    <= decode_ctrl(wr_data[4:0]);
            if (wr_reload) reload_q <= wr_data[PRE_W-1:0];
        end
    end

    // input conditioning: one synchronizer + edge picker per source
    logic [NUM_SRC-1:0] src_raw, src_fall, src_hit;
    assign src_raw  = {cap_hi_in, cap_lo_in, evt_in};
    assign src_fall = {cfg_q.cap_fall, cfg_q.cap_fall, cfg_q.evt_fall};

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        mtc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst      (rst),
            .en       (cyc_en),
            .din      (src_raw[g]),
            .fall_sel (src_fall[g]),
            .hit      (src_hit[g])
        );
    end

    logic tick;
    logic [PRE_W-1:0] pre_load_val;
    assign pre_load_val = wr_reload ? wr_data[PRE_W-1:0] : reload_q;

    mtc_prescaler #(.W(PRE_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .en     (cyc_en & cfg_q.run),
        .load   (wr_ctrl | wr_reload),
        .reload (pre_load_val),
        .tick   (tick)
    );

    logic [HALF_W-1:0] cnt_lo, cnt_hi;
    logic              wrap_lo, wrap_hi;

    mtc_count_core #(.HW(HALF_W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .clr     (wr_ctrl),
        .mode    (cfg_q.mode),
        .tick    (tick),
        .evt     (src_hit[SRC_EVT] & cfg_q.run),
        .lo      (cnt_lo),
        .hi      (cnt_hi),
        .wrap_lo (wrap_lo),
        .wrap_hi (wrap_hi)
    );

    // sticky flags: a set in the same cycle as a clear wins
    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_lo <= 1'b0;
            ovf_hi <= 1'b0;
        end else begin
            ovf_lo <= (ovf_lo & ~flag_clr_lo) | (wrap_lo & ~wide);
            ovf_hi <= (ovf_hi & ~flag_clr_hi) | wrap_hi;
        end
    end

    // capture: wide modes latch both halves from the low strobe in one edge
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_lo_q <= '0;
            cap_hi_q <= '0;
        end else begin
            if (src_hit[SRC_CAPLO]) begin
                cap_lo_q <= cnt_lo;
                if (wide) cap_hi_q <= cnt_hi;
            end
            if (src_hit[SRC_CAPHI] && !wide) cap_hi_q <= cnt_hi;
        end
    end
endmodule

// File: rtl/mtc_timer_chk.sv
module mtc_timer_chk #(
    parameter int HALF_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cyc_en,
    input logic [1:0]        mode_i,
    input logic              clr_lo_i,
    input logic              clr_hi_i,
    input logic [HALF_W-1:0] cap_lo_q,
    input logic [HALF_W-1:0] cap_hi_q,
    input logic              ovf_lo,
    input logic              ovf_hi
);
    // R1
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (cap_lo_q == '0 && cap_hi_q == '0 && !ovf_lo && !ovf_hi));

    // R10
    p_lo_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (ovf_lo && !clr_lo_i) |=> ovf_lo);

    // R10
    p_hi_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (ovf_hi && !clr_hi_i) |=> ovf_hi);

    // R10
    p_no_lo_flag_wide_r10: assert property (@(posedge clk) disable iff (rst)
        (mode_i[1] && !ovf_lo) |=> !ovf_lo);

    // R9
    p_cap_needs_enable_r9: assert property (@(posedge clk) disable iff (rst)
        !cyc_en |=> ($stable(cap_lo_q) && $stable(cap_hi_q)));

    // R9
    p_flag_needs_enable_r9: assert property (@(posedge clk) disable iff (rst)
        (!cyc_en && !ovf_lo && !ovf_hi) |=> (!ovf_lo && !ovf_hi));
endmodule

bind mtc_timer mtc_timer_chk #(.HALF_W(HALF_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cyc_en   (cyc_en),
    .mode_i   (cfg_q.mode),
    .clr_lo_i (flag_clr_lo),
    .clr_hi_i (flag_clr_hi),
    .cap_lo_q (cap_lo_q),
    .cap_hi_q (cap_hi_q),
    .ovf_lo   (ovf_lo),
    .ovf_hi   (ovf_hi)
);

// File: tb/mtc_timer_test.sv
module mtc_timer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cyc_en = 1'b1;
    logic       evt_in = 1'b0;
    logic       cap_lo_in = 1'b0;
    logic       cap_hi_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] cap_lo_q, cap_hi_q;
    logic       ovf_lo, ovf_hi;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit gate = 1'b0;
    int ph = 0;

    always #4 clk = ~clk;

    mtc_timer uut (
        .clk(clk), .rst(rst), .cyc_en(cyc_en), .evt_in(evt_in),
        .cap_lo_in(cap_lo_in), .cap_hi_in(cap_hi_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cap_lo_q(cap_lo_q), .cap_hi_q(cap_hi_q),
        .ovf_lo(ovf_lo), .ovf_hi(ovf_hi)
    );

    always @(negedge clk) begin
        ph     <= (ph + 1) % 4;
        cyc_en <= gate ? (ph == 0) : 1'b1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int d8(input int a, input int b);
        return (b - a) & 255;
    endfunction
    function automatic int d16(input int a, input int b);
        return (b - a) & 65535;
    endfunction
    function automatic int ticks(input int cycles, input int p);
        return cycles / (p + 1);
    endfunction
    function automatic int both(input logic [7:0] h, input logic [7:0] l);
        return int'({h, l});
    endfunction
    function automatic logic [7:0] ctl(input int mode, input bit run,
                                       input bit efall, input bit cfall);
        return {3'b000, cfall, efall, run, 2'(mode)};
    endfunction

    task automatic tickn(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic wr(input int a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask
    task automatic strobe_lo();
        cap_lo_in = 1'b1; tickn(8); cap_lo_in = 1'b0; tickn(8);
    endtask
    task automatic strobe_hi();
        cap_hi_in = 1'b1; tickn(8); cap_hi_in = 1'b0; tickn(8);
    endtask
    task automatic pulses(input int n, input int hi_t, input int lo_t, input bit idle);
        repeat (n) begin
            evt_in = ~idle; tickn(hi_t);
            evt_in = idle;  tickn(lo_t);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int a, b, ha, hb, m, p, k, n, pre_l, pre_h;
        void'($urandom(32'd5150));
        tickn(5);
        rst = 1'b0;
        tickn(2);

        // R1 reset state
        chk("R1 cap_lo", cap_lo_q, 0);
        chk("R1 cap_hi", cap_hi_q, 0);
        chk("R1 ovf_lo", ovf_lo, 0);
        chk("R1 ovf_hi", ovf_hi, 0);

        // R3 control write clears and reloads; slow prescale gives no tick yet
        wr(1, 8'd255);
        wr(0, ctl(0, 1, 0, 0));
        strobe_lo(); chk("R3 cleared lo", cap_lo_q, 0);
        strobe_hi(); chk("R3 cleared hi", cap_hi_q, 0);
        // R3 run=0 holds counters
        wr(1, 8'd0);
        wr(0, ctl(0, 0, 0, 0));
        tickn(50);
        strobe_lo(); chk("R3 stopped lo", cap_lo_q, 0);

        // R2 / R4 random prescale, mode 0, both halves
        for (int i = 0; i < 8; i++) begin
            p = $urandom_range(0, 7);
            m = $urandom_range(16, 40);
            k = (p + 1) * m;
            wr(1, 8'(p));
            wr(0, ctl(0, 1, 0, 0));
            strobe_lo(); a = cap_lo_q;
            tickn(k - 16);
            strobe_lo(); b = cap_lo_q;
            chk("R2 prescaled low timer", d8(a, b), ticks(k, p) & 255);
            strobe_hi(); ha = cap_hi_q;
            tickn(k - 16);
            strobe_hi(); hb = cap_hi_q;
            chk("R4 high timer", d8(ha, hb), ticks(k, p) & 255);
            chk("R4 high strobe leaves low capture", cap_lo_q, b);
        end

        // R5 mode 1: low timer, high event counter
        wr(1, 8'd1);
        wr(0, ctl(1, 1, 0, 0));
        n = $urandom_range(5, 20);
        strobe_lo(); a = cap_lo_q;
        strobe_hi(); ha = cap_hi_q;
        pulses(n, 2, 2, 1'b0);
        tickn(6);
        strobe_hi(); hb = cap_hi_q;
        strobe_lo(); b = cap_lo_q;
        chk("R5 high counts events", d8(ha, hb), n);
        chk("R5 low timer", d8(a, b), ticks(54 + 4 * n, 1) & 255);

        // R6 mode 2: 16-bit timer, single-edge capture
        wr(1, 8'd0);
        wr(0, ctl(2, 1, 0, 0));
        strobe_lo(); a = both(cap_hi_q, cap_lo_q);
        tickn(300 - 16);
        strobe_lo(); b = both(cap_hi_q, cap_lo_q);
        chk("R6 16-bit timer", d16(a, b), 300);
        pre_l = cap_lo_q; pre_h = cap_hi_q;
        strobe_hi();
        chk("R6 high strobe ignored lo", cap_lo_q, pre_l);
        chk("R6 high strobe ignored hi", cap_hi_q, pre_h);

        // R10 flags in mode 0
        wr(0, ctl(0, 1, 0, 0));
        wr(2, 8'd3);
        tickn(300);
        chk("R10 low flag set", ovf_lo, 1);
        chk("R10 high flag set", ovf_hi, 1);
        wr(0, ctl(0, 0, 0, 0));
        wr(2, 8'd1);
        tickn(2);
        chk("R10 low flag cleared", ovf_lo, 0);
        chk("R10 high flag kept", ovf_hi, 1);
        wr(2, 8'd2);
        tickn(2);
        chk("R10 high flag cleared", ovf_hi, 0);

        // R10 wide mode: only the 16-bit wrap raises a flag
        wr(0, ctl(2, 1, 0, 0));
        wr(2, 8'd3);
        tickn(300);
        chk("R10 wide no low flag", ovf_lo, 0);
        chk("R10 wide no early high flag", ovf_hi, 0);
        tickn(65300);
        chk("R10 wide high flag on 16-bit wrap", ovf_hi, 1);
        chk("R10 wide low flag stays low", ovf_lo, 0);
        wr(0, ctl(0, 0, 0, 0));
        wr(2, 8'd3);

        // R7 mode 3: 16-bit event counter across the byte boundary
        wr(0, ctl(3, 1, 0, 0));
        strobe_lo(); a = both(cap_hi_q, cap_lo_q);
        pulses(260, 2, 2, 1'b0);
        tickn(6);
        strobe_lo(); b = both(cap_hi_q, cap_lo_q);
        chk("R7 16-bit event count", d16(a, b), 260);

        // R8 falling event edge
        wr(0, ctl(3, 1, 1, 0));
        evt_in = 1'b1;
        tickn(6);
        strobe_lo(); a = both(cap_hi_q, cap_lo_q);
        pulses(7, 2, 2, 1'b1);
        tickn(6);
        strobe_lo(); b = both(cap_hi_q, cap_lo_q);
        chk("R8 falling events only", d16(a, b), 7);
        evt_in = 1'b0;
        tickn(6);

        // R8 falling capture edge on a running 16-bit timer
        wr(0, ctl(2, 1, 0, 1));
        tickn(4);
        pre_l = cap_lo_q; pre_h = cap_hi_q;
        cap_lo_in = 1'b1;
        tickn(20);
        chk("R8 rising strobe ignored", both(cap_hi_q, cap_lo_q), both(8'(pre_h), 8'(pre_l)));
        cap_lo_in = 1'b0;
        tickn(8);
        a = both(cap_hi_q, cap_lo_q);
        cap_lo_in = 1'b1;
        tickn(92);
        cap_lo_in = 1'b0;
        tickn(8);
        b = both(cap_hi_q, cap_lo_q);
        chk("R8 falling strobe capture interval", d16(a, b), 100);

        // R9 enabled-cycle sampling
        wr(0, ctl(3, 1, 0, 0));
        gate = 1'b1;
        tickn(8);
        strobe_lo(); a = both(cap_hi_q, cap_lo_q);
        pulses(4, 1, 4, 1'b0);
        tickn(8);
        strobe_lo(); b = both(cap_hi_q, cap_lo_q);
        chk("R9 short pulses seen once", d16(a, b), 1);
        pulses(4, 4, 4, 1'b0);
        tickn(8);
        strobe_lo(); a = both(cap_hi_q, cap_lo_q);
        chk("R9 full-cycle pulses counted", d16(b, a), 4);
        gate = 1'b0;
        tickn(4);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule